// File: doc/BRIEF.md
# Memory Ordering Issue Gate

The gate keeps a short queue of memory operations in program order. It decides, one cycle at a time, which queued operation may go to the memory system next. Each operation arrives with a tag and one of four ordering classes: free, release, acquire or fence. It also carries a flag that marks it as an access that must stay in order, and a 2-bit peripheral domain number. The gate may send younger operations ahead of older ones whenever none of the class or domain rules forbid it.

An operation counts as visible once the memory system returns its tag on the completion port. The entry then leaves the queue. Only tags and ordering state are stored. There is no data payload. The issue port has no backpressure: a pulse on it means the operation has been sent.

Top module: `mem_order_gate`

## Requirements
- R1: The queue holds DEPTH (default 8) entries. `disp_ready` is low exactly when DEPTH entries are live. A dispatch offered while `disp_ready` is low is dropped, and its tag later counts as unknown.
- R2: The class code is 0 = free, 1 = release, 2 = acquire, 3 = fence. A free operation may issue while older free operations are still waiting for completion.
- R3: A release or fence operation issues only after every older operation in the queue has completed.
- R4: After an acquire or fence operation, no younger operation issues until that operation has completed.
- R5: Among operations with the in-order flag set and the same domain, an operation does not issue while an older one of them has not issued.
- R6: The in-order flag adds no ordering against operations in another domain or without the flag.
- R7: A flagged operation waits for its flagged same-domain predecessor only until that predecessor issues, not until it completes. It can issue in the cycle right after the predecessor issues.
- R8: At most one operation issues per cycle: the oldest one whose rules are all met. An operation dispatched in cycle N can first issue in cycle N+1. `iss_valid` and `iss_tag` depend only on the stored state.
- R9: A completion whose tag matches an issued queued entry removes that entry. Entries that are blocked only by it can issue in the next cycle.
- R10: A completion whose tag matches no issued queued entry raises `stray_err` in the same cycle and leaves the queue unchanged.
- R11: A synchronous active-high reset empties the queue. Afterwards `iss_valid` is 0, `disp_ready` is 1, and earlier tags count as unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Queue can accept a dispatch |
| disp_class | input | 2 | Ordering class code |
| disp_seq | input | 1 | In-order access flag |
| disp_dom | input | 2 | Peripheral domain number |
| disp_tag | input | 4 | Operation tag |
| done_valid | input | 1 | Completion strobe |
| done_tag | input | 4 | Tag of the completed operation |
| iss_valid | output | 1 | An operation is sent this cycle |
| iss_tag | output | 4 | Tag of the sent operation |
| stray_err | output | 1 | Completion tag was not issued and queued |

## Verification
A corrupted class, domain or issued bit shows at the ports as an operation that issues one cycle too early or too late. Pairs and triples of operations are replayed across every class pair and every domain pair, so such a slip appears within a few cycles of the dispatch that exposes it. A wrong count or a bad compaction shows as `disp_ready` at the wrong level, or as an out-of-order tag stream while a full queue drains. A matching fault shows as a missing or false `stray_err` in the same cycle as the completion.

// File: rtl/mog_pkg.sv
package mog_pkg;

    parameter int unsigned MOG_TAG_W = 4;
    parameter int unsigned MOG_DOM_W = 2;

    typedef enum logic [1:0] {
        ORD_FREE  = 2'd0,
        ORD_REL   = 2'd1,
        ORD_ACQ   = 2'd2,
        ORD_FENCE = 2'd3
    } ord_class_e;

    typedef struct packed {
        ord_class_e             cls;
        logic                   seq;
        logic [MOG_DOM_W-1:0]   dom;
        logic [MOG_TAG_W-1:0]   tag;
        logic                   issued;
    } mog_entry_t;

    // the entry must wait for all older entries to complete
    function automatic logic waits_older(ord_class_e c);
        return (c == ORD_REL) || (c == ORD_FENCE);
    endfunction

    // the entry holds back every younger entry until it completes
    function automatic logic holds_younger(ord_class_e c);
        return (c == ORD_ACQ) || (c == ORD_FENCE);
    endfunction

endpackage

// File: rtl/mog_pick.sv
module mog_pick #(
    parameter int unsigned N = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IDX_W'(k);
        end
        any = |req;
    end
endmodule

// File: rtl/mog_elig.sv
module mog_elig
    import mog_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  mog_entry_t [DEPTH-1:0] q,
    input  logic [CNT_W-1:0]       cnt,
    output logic [DEPTH-1:0]       elig
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic blk;
        always_comb begin
            blk = waits_older(q[i].cls) && (i != 0);
            for (int j = 0; j < i; j++) begin
                if (holds_younger(q[j].cls)) blk = 1'b1;
                if (q[i].seq && q[j].seq && !q[j].issued && (q[j].dom == q[i].dom))
                    blk = 1'b1;
            end
        end
        assign elig[i] = (CNT_W'(i) < cnt) && !q[i].issued && !blk;
    end
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate
    import mog_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 disp_valid,
    output logic                 disp_ready,
    input  logic [1:0]           disp_class,
    input  logic                 disp_seq,
    input  logic [MOG_DOM_W-1:0] disp_dom,
    input  logic [MOG_TAG_W-1:0] disp_tag,
    input  logic                 done_valid,
    input  logic [MOG_TAG_W-1:0] done_tag,
    output logic                 iss_valid,
    output logic [MOG_TAG_W-1:0] iss_tag,
    output logic                 stray_err
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    mog_entry_t [DEPTH-1:0] q, q_mark, q_n;
    logic [CNT_W-1:0]       cnt, cnt_after, cnt_n;
    logic [DEPTH-1:0]       elig, hit_vec;
    logic                   elig_any, hit_any, disp_fire;
    logic [IDX_W-1:0]       pick_idx, hit_idx;

    mog_elig #(.DEPTH(DEPTH)) u_elig (
        .q    (q),
        .cnt  (cnt),
        .elig (elig)
    );

    mog_pick #(.N(DEPTH)) u_pick_issue (
        .req (elig),
        .any (elig_any),
        .idx (pick_idx)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        assign hit_vec[i] = done_valid && (CNT_W'(i) < cnt) && q[i].issued
                            && (q[i].tag == done_tag);
    end

    mog_pick #(.N(DEPTH)) u_pick_done (
        .req (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    assign disp_ready = (cnt < CNT_W'(DEPTH));
    assign disp_fire  = disp_valid && disp_ready;
    assign iss_valid  = elig_any;
    assign iss_tag    = q[pick_idx].tag;
    assign stray_err  = done_valid && !hit_any;

    always_comb begin
        q_mark = q;
        if (elig_any) q_mark[pick_idx].issued = 1'b1;

        q_n = q_mark;
        if (hit_any) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= hit_idx) q_n[i] = q_mark[i+1];
            end
            q_n[DEPTH-1] = '0;
        end

        cnt_after = cnt - CNT_W'(hit_any);
        if (disp_fire) begin
            q_n[cnt_after[IDX_W-1:0]] = '{
                cls:    ord_class_e'(disp_class),
                seq:    disp_seq,
                dom:    disp_dom,
                tag:    disp_tag,
                issued: 1'b0
            };
        end
        cnt_n = cnt_after + CNT_W'(disp_fire);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            q   <= '0;
        end else begin
            cnt <= cnt_n;
            q   <= q_n;
        end
    end
endmodule

// File: rtl/mog_checker.sv
module mog_checker
    import mog_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [CNT_W-1:0]       cnt,
    input mog_entry_t [DEPTH-1:0] q,
    input logic [IDX_W-1:0]       pick,
    input logic                   iss_valid,
    input logic                   disp_fire,
    input logic                   done_valid,
    input logic                   stray_err
);
    logic acq_bad, seq_bad;

    always_comb begin
        acq_bad = 1'b0;
        seq_bad = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (IDX_W'(j) < pick) begin
                if (holds_younger(q[j].cls)) acq_bad = 1'b1;
                if (q[pick].seq && q[j].seq && !q[j].issued && (q[j].dom == q[pick].dom))
                    seq_bad = 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH)); // R1

    AST_REL_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
        iss_valid && waits_older(q[pick].cls) |-> pick == '0); // R3

    AST_ACQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !acq_bad); // R4

    AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !seq_bad); // R5

    AST_ISSUE_LIVE: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> cnt != '0); // R8

    AST_RETIRE_ONE: assert property (@(posedge clk) disable iff (rst)
        done_valid && !stray_err && !disp_fire |=> $past(cnt) == cnt + CNT_W'(1)); // R9

    AST_STRAY_HOLD: assert property (@(posedge clk) disable iff (rst)
        stray_err && !disp_fire |=> cnt == $past(cnt)); // R10
endmodule

bind mem_order_gate mog_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt        (cnt),
    .q          (q),
    .pick       (pick_idx),
    .iss_valid  (iss_valid),
    .disp_fire  (disp_fire),
    .done_valid (done_valid),
    .stray_err  (stray_err)
);

// File: tb/mem_order_gate_test.sv
module mem_order_gate_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       disp_valid = 1'b0;
    logic       disp_ready;
    logic [1:0] disp_class = '0;
    logic       disp_seq = 1'b0;
    logic [1:0] disp_dom = '0;
    logic [3:0] disp_tag = '0;
    logic       done_valid = 1'b0;
    logic [3:0] done_tag = '0;
    logic       iss_valid;
    logic [3:0] iss_tag;
    logic       stray_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_order_gate uut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_class(disp_class), .disp_seq(disp_seq),
        .disp_dom(disp_dom), .disp_tag(disp_tag),
        .done_valid(done_valid), .done_tag(done_tag),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .stray_err(stray_err)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // expected issue: -1 means no issue this cycle
    task automatic check_iss(input int et, input string rq);
        int act;
        act = iss_valid ? int'(iss_tag) : -1;
        check(act == et, rq, "issue tag (-1 none)", act, et);
    endtask

    // one clock cycle: check issue, drive inputs, check error, clock
    task automatic cyc(input int dv, input int cls, input int sq, input int dm, input int tg,
                       input int cv, input int ct, input int et, input int ee,
                       input string rq);
        check_iss(et, rq);
        disp_valid = dv[0];
        disp_class = 2'(cls);
        disp_seq   = sq[0];
        disp_dom   = 2'(dm);
        disp_tag   = 4'(tg);
        done_valid = cv[0];
        done_tag   = 4'(ct);
        #1;
        check(int'(stray_err) == ee, rq, "stray_err", int'(stray_err), ee);
        @(posedge clk);
        #1;
        disp_valid = 1'b0;
        done_valid = 1'b0;
    endtask

    task automatic do_reset();
        disp_valid = 1'b0;
        done_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        // R11: reset state
        check_iss(-1, "R11");
        check(disp_ready == 1'b1, "R11", "disp_ready", int'(disp_ready), 1);

        // class pair sweep: older A (tag 1) then younger B (tag 2)
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                bit ok_b;
                ok_b = !(a == 2 || a == 3) && !(b == 1 || b == 3);
                do_reset();
                cyc(1, a, 0, 0, 1, 0, 0, -1, 0, "R8");
                cyc(1, b, 0, 0, 2, 0, 0, 1, 0, "R8");
                cyc(0, 0, 0, 0, 0, 1, 1, ok_b ? 2 : -1, 0, "R2 R3 R4");
                cyc(0, 0, 0, 0, 0, 0, 0, ok_b ? -1 : 2, 0, "R9 R3 R4");
                cyc(0, 0, 0, 0, 0, 1, 2, -1, 0, "R9");
                check(disp_ready == 1'b1, "R9", "disp_ready after drain", int'(disp_ready), 1);
            end
        end

        // in-order flag sweep: H free, X release flagged dom d, Y free flag ys dom e
        for (int d = 0; d < 4; d++) begin
            for (int e = 0; e < 4; e++) begin
                for (int ys = 0; ys < 2; ys++) begin
                    bit y_free;
                    y_free = (ys == 0) || (d != e);
                    do_reset();
                    cyc(1, 0, 0, 0, 1, 0, 0, -1, 0, "R8");
                    cyc(1, 1, 1, d, 2, 0, 0, 1, 0, "R3");
                    cyc(1, 0, ys, e, 3, 0, 0, -1, 0, "R3");
                    cyc(0, 0, 0, 0, 0, 1, 1, y_free ? 3 : -1, 0, "R5 R6");
                    cyc(0, 0, 0, 0, 0, 0, 0, 2, 0, "R3 R9");
                    cyc(0, 0, 0, 0, 0, 0, 0, y_free ? -1 : 3, 0, "R7");
                end
            end
        end

        // full queue and oldest-first drain
        do_reset();
        cyc(1, 2, 0, 0, 0, 0, 0, -1, 0, "R1");
        for (int t = 1; t < 8; t++)
            cyc(1, 0, 0, 0, t, 0, 0, (t == 1) ? 0 : -1, 0, "R4");
        check(disp_ready == 1'b0, "R1", "disp_ready when full", int'(disp_ready), 0);
        cyc(1, 0, 0, 0, 9, 0, 0, -1, 0, "R1");
        cyc(0, 0, 0, 0, 0, 1, 0, -1, 0, "R9");
        check(disp_ready == 1'b1, "R1", "disp_ready after retire", int'(disp_ready), 1);
        for (int t = 1; t < 8; t++)
            cyc(0, 0, 0, 0, 0, 0, 0, t, 0, "R8");
        cyc(0, 0, 0, 0, 0, 1, 9, -1, 1, "R1");

        // R11: reset mid-traffic forgets tags
        do_reset();
        check_iss(-1, "R11");
        check(disp_ready == 1'b1, "R11", "disp_ready", int'(disp_ready), 1);
        cyc(0, 0, 0, 0, 0, 1, 1, -1, 1, "R11");

        // R10: unknown tag, and completion of a not-yet-issued tag
        do_reset();
        cyc(1, 0, 0, 0, 5, 0, 0, -1, 0, "R10");
        cyc(0, 0, 0, 0, 0, 1, 6, 5, 1, "R10");
        cyc(0, 0, 0, 0, 0, 1, 5, -1, 0, "R10");
        do_reset();
        cyc(1, 2, 0, 0, 1, 0, 0, -1, 0, "R10");
        cyc(1, 0, 0, 0, 2, 0, 0, 1, 0, "R10");
        cyc(0, 0, 0, 0, 0, 1, 2, -1, 1, "R10");
        cyc(0, 0, 0, 0, 0, 1, 1, -1, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 2, 0, "R10");
        cyc(0, 0, 0, 0, 0, 1, 2, -1, 0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule